// File: doc/BRIEF.md
# Masked Interrupt Summary Controller

This block collects sticky event bits from four event registers (power, detect, fault and supply) and condenses them into an 8-bit interrupt summary. Six summary bits each follow one chosen bit of the power, detect or fault register. One summary bit is the OR of the whole supply register. One bit is reserved and always reads zero.

A per-bit mask decides which summary bits may raise the interrupt line. The line is open-drain and active-low. It is presented as a level (`irq_n_o`) plus an output-enable (`irq_oe_o`). The line is actively pulled low only while the global enable is set and at least one unmasked summary bit is 1. In every other case the enable is dropped and the pad floats.

Surrounding logic drives one-cycle set pulses into the event registers. A small register port carries software writes: the mask, the global enable and a self-clearing clear-all command. Every register can be read back through an asynchronous read port.

Top module: `int_summary_ctrl`

## Requirements
- R1: Summary bit 0 mirrors power event bit 0, bit 1 mirrors power bit 4, bit 2 mirrors fault bit 4, bit 3 mirrors detect bit 0, bit 4 mirrors detect bit 4, and bit 5 mirrors fault bit 0. Other event bits leave these summary bits at 0.
- R2: Summary bit 7 is 1 exactly when any supply event bit is 1. Summary bit 6 always reads 0.
- R3: After reset, all event registers, the summary, the mask and the enable read 0x00, and `irq_oe_o` is 0 with `irq_n_o` at 1.
- R4: A 1 on any bit of an event set input sets that register bit at the next clock edge. The bit then stays 1 until a clear-all command.
- R5: While the enable is 1 and some summary bit is 1 with its mask bit at 0, `irq_oe_o` is 1 and `irq_n_o` is 0.
- R6: A summary bit whose mask bit is 1 never drives the interrupt line. Writing address 1 loads the mask.
- R7: While the enable is 0, `irq_oe_o` is 0 whatever the summary and mask hold.
- R8: Writing address 2 with data bit 1 set clears all four event registers at the next edge, and with them the summary. A set pulse in the same cycle wins, and its bit stays 1.
- R9: Address 2 data bit 0 is the global enable. The clear bit is not stored: address 2 always reads back as {7'b0, enable}.
- R10: While enabled with no unmasked summary bit set, the line is released: `irq_oe_o` is 0 and `irq_n_o` is 1.
- R11: The read map is: 0 summary, 1 mask, 2 control, 3 power, 4 detect, 5 fault, 6 supply, 7 reads 0x00. Writes to any address other than 1 or 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_set_i | input | EVT_W | Power event set pulses |
| det_set_i | input | EVT_W | Detect event set pulses |
| flt_set_i | input | EVT_W | Fault event set pulses |
| sup_set_i | input | EVT_W | Supply event set pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_n_o | output | 1 | Interrupt level, low when asserted |
| irq_oe_o | output | 1 | Interrupt pad output-enable |

## Verification
The bench builds the block with its default parameters: eight-bit event registers and the mirrored bits at positions 0 and 4. With these values it can pulse both the designated bits and the non-designated bits (2, 5, 7) of every event register, and confirm that only the designated ones reach the summary. It can also spread supply events across the full byte, which exercises the OR feeding bit 7. A cycle-accurate behavioural model then follows long stretches of sparse random pulses, mask changes, enable changes and clear commands that land on set pulses.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SUM  = 3'd0,
    A_MASK = 3'd1,
    A_CTRL = 3'd2,
    A_PWR  = 3'd3,
    A_DET  = 3'd4,
    A_FLT  = 3'd5,
    A_SUP  = 3'd6,
    A_NONE = 3'd7
  } isc_addr_e;

  localparam int unsigned EV_PWR = 0;
  localparam int unsigned EV_DET = 1;
  localparam int unsigned EV_FLT = 2;
  localparam int unsigned EV_SUP = 3;

  // summary bit positions
  localparam int unsigned S_PEN  = 0;
  localparam int unsigned S_PG   = 1;
  localparam int unsigned S_LD   = 2;
  localparam int unsigned S_DET  = 3;
  localparam int unsigned S_CL   = 4;
  localparam int unsigned S_IMAX = 5;
  localparam int unsigned S_RSV  = 6;
  localparam int unsigned S_SUP  = 7;

  localparam int unsigned C_EN  = 0;
  localparam int unsigned C_CLR = 1;
endpackage

// File: rtl/isc_evt_reg.sv
module isc_evt_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (clr_i) q_q <= set_i;
    else            q_q <= q_q | set_i;
  end

  assign q_o = q_q;

  p_sticky_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(q_o) & ~q_o) == '0));
  p_set_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  p_clear_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (q_o == '0));
endmodule

// File: rtl/isc_summary.sv
module isc_summary
  import isc_pkg::*;
#(
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned PEN_BIT = 0,
  parameter int unsigned PG_BIT  = 4,
  parameter int unsigned DET_BIT = 0,
  parameter int unsigned CL_BIT  = 4,
  parameter int unsigned IMX_BIT = 0,
  parameter int unsigned LD_BIT  = 4
) (
  input  logic [EVT_W-1:0] pwr_i,
  input  logic [EVT_W-1:0] det_i,
  input  logic [EVT_W-1:0] flt_i,
  input  logic [EVT_W-1:0] sup_i,
  output logic [REG_W-1:0] sum_o
);
  always_comb begin
    sum_o         = '0;
    sum_o[S_PEN]  = pwr_i[PEN_BIT];
    sum_o[S_PG]   = pwr_i[PG_BIT];
    sum_o[S_LD]   = flt_i[LD_BIT];
    sum_o[S_DET]  = det_i[DET_BIT];
    sum_o[S_CL]   = det_i[CL_BIT];
    sum_o[S_IMAX] = flt_i[IMX_BIT];
    sum_o[S_RSV]  = 1'b0;
    sum_o[S_SUP]  = |sup_i;
  end
endmodule

// File: rtl/isc_cfg.sv
module isc_cfg
  import isc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  mask_o,
  output logic              en_o,
  output logic              clr_o
);
  logic [REG_W-1:0] mask_q;
  logic             en_q;
  logic             wr_mask, wr_ctrl;

  assign wr_mask = wr_en_i && (wr_addr_i == A_MASK);
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wr_data_i;
      if (wr_ctrl) en_q   <= wr_data_i[C_EN];
    end
  end

  // clear is a write strobe, never stored
  assign clr_o  = wr_ctrl && wr_data_i[C_CLR];
  assign mask_o = mask_q;
  assign en_o   = en_q;

  p_mask_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_MASK) |=> $stable(mask_o));
  p_en_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_CTRL) |=> $stable(en_o));
endmodule

// File: rtl/int_summary_ctrl.sv
module int_summary_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned PEN_BIT = 0,
  parameter int unsigned PG_BIT  = 4,
  parameter int unsigned DET_BIT = 0,
  parameter int unsigned CL_BIT  = 4,
  parameter int unsigned IMX_BIT = 0,
  parameter int unsigned LD_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  pwr_set_i,
  input  logic [EVT_W-1:0]  det_set_i,
  input  logic [EVT_W-1:0]  flt_set_i,
  input  logic [EVT_W-1:0]  sup_set_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic [EVT_W-1:0] ev_set [NUM_EVT];
  logic [EVT_W-1:0] ev_q   [NUM_EVT];
  logic [REG_W-1:0] sum, mask, pend;
  logic             en, clr, drive;

  assign ev_set[EV_PWR] = pwr_set_i;
  assign ev_set[EV_DET] = det_set_i;
  assign ev_set[EV_FLT] = flt_set_i;
  assign ev_set[EV_SUP] = sup_set_i;

  isc_cfg i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask),
    .en_o      (en),
    .clr_o     (clr)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    isc_evt_reg #(.W(EVT_W)) i_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_set[g]),
      .clr_i  (clr),
      .q_o    (ev_q[g])
    );
  end

  isc_summary #(
    .EVT_W(EVT_W), .PEN_BIT(PEN_BIT), .PG_BIT(PG_BIT), .DET_BIT(DET_BIT),
    .CL_BIT(CL_BIT), .IMX_BIT(IMX_BIT), .LD_BIT(LD_BIT)
  ) i_sum (
    .pwr_i (ev_q[EV_PWR]),
    .det_i (ev_q[EV_DET]),
    .flt_i (ev_q[EV_FLT]),
    .sup_i (ev_q[EV_SUP]),
    .sum_o (sum)
  );

  assign pend  = sum & ~mask;
  assign drive = en && (pend != '0);

  // open-drain pad: drive low or release
  assign irq_oe_o = drive;
  assign irq_n_o  = ~drive;

  always_comb begin
    unique case (rd_addr_i)
      A_SUM:   rd_data_o = sum;
      A_MASK:  rd_data_o = mask;
      A_CTRL:  rd_data_o = REG_W'(en);
      A_PWR:   rd_data_o = REG_W'(ev_q[EV_PWR]);
      A_DET:   rd_data_o = REG_W'(ev_q[EV_DET]);
      A_FLT:   rd_data_o = REG_W'(ev_q[EV_FLT]);
      A_SUP:   rd_data_o = REG_W'(ev_q[EV_SUP]);
      default: rd_data_o = '0;
    endcase
  end

  p_irq_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && (sum & ~mask) != '0) |-> (irq_oe_o && !irq_n_o));
  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sum & ~mask) == '0) |-> !irq_oe_o);
  p_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_oe_o);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> irq_n_o);
  p_clear_sum_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && pwr_set_i == '0 && det_set_i == '0 && flt_set_i == '0 && sup_set_i == '0)
      |=> (sum == '0));
endmodule

// File: tb/test_int_summary_ctrl.sv
`timescale 1ns/1ps
module test_int_summary_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pwr_set = '0, det_set = '0, flt_set = '0, sup_set = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n, irq_oe;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R3";

  // reference model state
  int m_ev [4];
  int m_mask = 0;
  int m_en   = 0;

  always #4 clk = ~clk;

  int_summary_ctrl i_int_summary_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .pwr_set_i(pwr_set), .det_set_i(det_set), .flt_set_i(flt_set), .sup_set_i(sup_set),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  function automatic int m_sum();
    int s = 0;
    s |= bitof(m_ev[0], 0) << 0;
    s |= bitof(m_ev[0], 4) << 1;
    s |= bitof(m_ev[2], 4) << 2;
    s |= bitof(m_ev[1], 0) << 3;
    s |= bitof(m_ev[1], 4) << 4;
    s |= bitof(m_ev[2], 0) << 5;
    s |= (m_ev[3] != 0) << 7;
    return s;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_sum();
      1: return m_mask;
      2: return m_en;
      3, 4, 5, 6: return m_ev[a-3];
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, model update at posedge
  task automatic cyc(input int p, input int d, input int f, input int s,
                     input bit we, input int wa, input int wd, input int ra);
    bit drv, clr;
    @(negedge clk);
    pwr_set = 8'(p); det_set = 8'(d); flt_set = 8'(f); sup_set = 8'(s);
    wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd); rd_addr = 3'(ra);
    #1;
    drv = (m_en != 0) && ((m_sum() & ~m_mask & 8'hff) != 0);
    check($sformatf("rd_data[%0d]", ra), int'(rd_data), m_read(ra));
    check("irq_oe", int'(irq_oe), int'(drv));
    check("irq_n", int'(irq_n), int'(!drv));
    @(posedge clk);
    clr = we && (wa == 2) && ((wd >> 1) & 1);
    if (we && wa == 1) m_mask = wd & 8'hff;
    if (we && wa == 2) m_en = wd & 1;
    m_ev[0] = (clr ? 0 : m_ev[0]) | p;
    m_ev[1] = (clr ? 0 : m_ev[1]) | d;
    m_ev[2] = (clr ? 0 : m_ev[2]) | f;
    m_ev[3] = (clr ? 0 : m_ev[3]) | s;
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, 0, 0, 0, 0, a);
  endtask

  task automatic wr(int a, int d);
    cyc(0, 0, 0, 0, 1, a, d, 0);
  endtask

  task automatic pulse(int p, int d, int f, int s);
    cyc(p, d, f, s, 0, 0, 0, 0);
  endtask

  task automatic clear_all();
    wr(2, 8'h03);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_ev[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R3"; read_all();

    cur_req = "R9"; wr(2, 8'h01); read_all();
    cur_req = "R1";
    for (int b = 0; b < 8; b++) begin
      pulse(1 << b, 0, 0, 0); read_all(); clear_all();
      pulse(0, 1 << b, 0, 0); read_all(); clear_all();
      pulse(0, 0, 1 << b, 0); read_all(); clear_all();
    end
    cur_req = "R2";
    for (int b = 0; b < 8; b++) begin
      pulse(0, 0, 0, 1 << b); read_all(); clear_all();
    end
    cur_req = "R4";
    pulse(8'h11, 0, 0, 0); pulse(0, 8'h01, 0, 0);
    repeat (20) cyc(0, 0, 0, 0, 0, 0, 0, 3);
    read_all();
    cur_req = "R6"; wr(1, 8'hff); read_all(); wr(1, 8'h08); read_all();
    cur_req = "R5"; wr(1, 8'h00); read_all();
    cur_req = "R7"; wr(2, 8'h00); read_all(); wr(2, 8'h01);
    cur_req = "R8";
    cyc(8'h01, 0, 0, 8'h20, 1, 2, 8'h03, 0); read_all();
    clear_all(); read_all();
    cur_req = "R9"; cyc(0, 0, 0, 0, 1, 2, 8'h03, 2); read_all();
    cur_req = "R10"; read_all();
    cur_req = "R11";
    pulse(8'h01, 0, 0, 0);
    for (int a = 0; a < 8; a++) if (a != 1 && a != 2) wr(a, 8'hff);
    read_all(); clear_all();

    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      int p = (r < 6) ? int'($urandom_range(0, 255)) : 0;
      int d = (r > 93) ? int'($urandom_range(0, 255)) : 0;
      int f = (r == 50) ? int'($urandom_range(0, 255)) : 0;
      int s = (r == 51) ? int'($urandom_range(0, 255)) : 0;
      int k = int'($urandom_range(0, 99));
      if (k < 3)      cyc(p, d, f, s, 1, 2, int'($urandom_range(0, 3)), i % 8);
      else if (k < 6) cyc(p, d, f, s, 1, 1, int'($urandom_range(0, 255)), i % 8);
      else            cyc(p, d, f, s, 0, 0, 0, i % 8);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule